// File: doc/BRIEF.md
# Multiplicative segment identifier scrambler

This block turns an effective segment number into a scattered 36-bit virtual segment identifier (VSID). It first builds a 36-bit proto identifier: in kernel mode the proto is the segment number as given; in user mode it is the context number placed above the low 16 bits of the segment number. The proto is then multiplied by the fixed prime 200730139. The 64-bit product is reduced modulo 2^36−1 with no divider. The bits above bit 35 are added to the low 36 bits. The folded sum then gets one more +1 when bit 36 of (sum + 1) is set, and the result is cut to 36 bits.

The unit is fully pipelined. A request strobed on `start_i` gives a one-cycle `done_o` pulse three cycles later, and a new request can enter on every cycle. A flag travels with each result and marks proto values that lie in reserved space: the all-ones value, or the `10` pattern in the two top bits. The result is still computed for flagged inputs. The output registers keep the last result until the next completion.

Top module: `vsid_scramble`

## Requirements
- R1: With `kernel_i`=1 the proto is `esid_i` (all 36 bits), and `vsid_o` = (proto × 200730139) mod (2^36−1).
- R2: With `kernel_i`=0 the proto is bit 35 = 0, bits 34..16 = `ctx_i`, bits 15..0 = `esid_i[15:0]`; `esid_i[35:16]` has no effect on `vsid_o` or `rsvd_o`.
- R3: `done_o` is high in cycle c+3 exactly when `start_i` was high in cycle c; each start gives exactly one done pulse.
- R4: Requests on consecutive cycles are all accepted, and each result comes out in issue order.
- R5: When `done_o` is high, `vsid_o` is never 0xFFFFFFFFF.
- R6: `rsvd_o` is high together with `done_o` exactly when the proto is 0xFFFFFFFFF or its bits 35..34 are `10`. User-mode requests are therefore never flagged.
- R7: A proto of zero yields `vsid_o` = 0.
- R8: While `rst_ni` is low, `done_o`, `rsvd_o` and `vsid_o` are all zero.
- R9: While `done_o` is low, `vsid_o` and `rsvd_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one request per high cycle |
| kernel_i | input | 1 | 1 = kernel proto form, 0 = user proto form |
| esid_i | input | 36 | Effective segment number |
| ctx_i | input | 19 | Context number, used in user form |
| done_o | output | 1 | Result valid pulse |
| vsid_o | output | 36 | Scrambled segment identifier |
| rsvd_o | output | 1 | Proto lay in reserved space |

## Verification
The latency and flag properties assume that `start_i`, `kernel_i` and `esid_i` are stable across each sampled edge and that `start_i` is low during reset, so that the three-cycle look-back sees real requests only. The bench drives all inputs on the falling edge and holds `start_i` low until after reset is released. Random requests, about seventy percent dense, are mixed with directed cases: zero, all-ones kernel segments, the reserved `10` prefix, maximal user contexts and unbroken bursts. Every result is compared against a direct 64-bit modulo computation.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
  localparam int unsigned ID_W    = 36;
  localparam int unsigned MULT_W  = 28;
  localparam logic [MULT_W-1:0] MULT = 28'd200730139;
  localparam int unsigned CTX_W   = 19;
  localparam int unsigned UESID_W = 16;
  localparam int unsigned N_SLICE = 2;
endpackage

// File: rtl/vsid_proto_form.sv
module vsid_proto_form #(
  parameter int unsigned ID_W    = 36,
  parameter int unsigned CTX_W   = 19,
  parameter int unsigned UESID_W = 16
) (
  input  logic              kernel_i,
  input  logic [ID_W-1:0]   esid_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic [ID_W-1:0]   proto_o,
  output logic              rsvd_o
);
  logic [ID_W-1:0] user_proto;

  assign user_proto = ID_W'({ctx_i, esid_i[UESID_W-1:0]});
  assign proto_o    = kernel_i ? esid_i : user_proto;
  // all-ones is outside the scramble domain; 10 prefix is unallocated space
  assign rsvd_o     = (&proto_o) || (proto_o[ID_W-1 -: 2] == 2'b10);
endmodule

// File: rtl/vsid_mul_pipe.sv
module vsid_mul_pipe #(
  parameter int unsigned ID_W    = 36,
  parameter int unsigned MULT_W  = 28,
  parameter logic [MULT_W-1:0] MULT = '0,
  parameter int unsigned N_SLICE = 2,
  localparam int unsigned SLICE_W = (MULT_W + N_SLICE - 1) / N_SLICE,
  localparam int unsigned PP_W    = ID_W + SLICE_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           vld_i,
  input  logic                           rsvd_i,
  input  logic [ID_W-1:0]                proto_i,
  output logic                           vld_o,
  output logic                           rsvd_o,
  output logic [N_SLICE-1:0][PP_W-1:0]   pp_o
);
  localparam int unsigned PAD_W = N_SLICE * SLICE_W;
  localparam logic [PAD_W-1:0] MULT_PAD = PAD_W'(MULT);

  logic            vld_a, rsvd_a;
  logic [ID_W-1:0] proto_a;

  // stage A: capture operand
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_a   <= 1'b0;
      rsvd_a  <= 1'b0;
      proto_a <= '0;
    end else begin
      vld_a <= vld_i;
      if (vld_i) begin
        rsvd_a  <= rsvd_i;
        proto_a <= proto_i;
      end
    end
  end

  // stage B: one narrow partial product per multiplier slice
  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    localparam logic [SLICE_W-1:0] M_S = MULT_PAD[s*SLICE_W +: SLICE_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pp_o[s] <= '0;
      else if (vld_a) pp_o[s] <= PP_W'(proto_a) * PP_W'(M_S);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      rsvd_o <= 1'b0;
    end else begin
      vld_o <= vld_a;
      if (vld_a) rsvd_o <= rsvd_a;
    end
  end
endmodule

// File: rtl/vsid_fold.sv
module vsid_fold #(
  parameter int unsigned ID_W    = 36,
  parameter int unsigned MULT_W  = 28,
  parameter int unsigned N_SLICE = 2,
  localparam int unsigned SLICE_W = (MULT_W + N_SLICE - 1) / N_SLICE,
  localparam int unsigned PP_W    = ID_W + SLICE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vld_i,
  input  logic                          rsvd_i,
  input  logic [N_SLICE-1:0][PP_W-1:0]  pp_i,
  output logic                          vld_o,
  output logic                          rsvd_o,
  output logic [ID_W-1:0]               vsid_o
);
  localparam int unsigned PROD_W = ID_W + MULT_W;
  localparam int unsigned HI_W   = PROD_W - ID_W;

  logic [PROD_W-1:0] prod;
  logic [HI_W-1:0]   prod_hi;
  logic [ID_W:0]     fold, fold_inc;
  logic [ID_W-1:0]   res;

  always_comb begin
    prod = '0;
    for (int s = 0; s < N_SLICE; s++)
      prod = prod + (PROD_W'(pp_i[s]) << (s * SLICE_W));
  end

  // end-around fold, then one conditional +1 taken from carry of fold+1
  assign prod_hi  = prod[PROD_W-1:ID_W];
  assign fold     = {1'b0, prod[ID_W-1:0]} + (ID_W+1)'(prod_hi);
  assign fold_inc = fold + (ID_W+1)'(1);
  assign res      = fold[ID_W-1:0] + ID_W'(fold_inc[ID_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      rsvd_o <= 1'b0;
      vsid_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        rsvd_o <= rsvd_i;
        vsid_o <= res;
      end
    end
  end
endmodule

// File: rtl/vsid_scramble.sv
module vsid_scramble
  import vsid_pkg::*;
#(
  parameter int unsigned ID_W    = vsid_pkg::ID_W,
  parameter int unsigned MULT_W  = vsid_pkg::MULT_W,
  parameter logic [MULT_W-1:0] MULT = vsid_pkg::MULT,
  parameter int unsigned CTX_W   = vsid_pkg::CTX_W,
  parameter int unsigned UESID_W = vsid_pkg::UESID_W,
  parameter int unsigned N_SLICE = vsid_pkg::N_SLICE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              kernel_i,
  input  logic [ID_W-1:0]   esid_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic              done_o,
  output logic [ID_W-1:0]   vsid_o,
  output logic              rsvd_o
);
  localparam int unsigned SLICE_W = (MULT_W + N_SLICE - 1) / N_SLICE;
  localparam int unsigned PP_W    = ID_W + SLICE_W;

  logic [ID_W-1:0]              proto;
  logic                         proto_rsvd;
  logic                         mul_vld, mul_rsvd;
  logic [N_SLICE-1:0][PP_W-1:0] mul_pp;

  vsid_proto_form #(.ID_W(ID_W), .CTX_W(CTX_W), .UESID_W(UESID_W)) u_form (
    .kernel_i (kernel_i),
    .esid_i   (esid_i),
    .ctx_i    (ctx_i),
    .proto_o  (proto),
    .rsvd_o   (proto_rsvd)
  );

  vsid_mul_pipe #(.ID_W(ID_W), .MULT_W(MULT_W), .MULT(MULT), .N_SLICE(N_SLICE)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (start_i),
    .rsvd_i  (proto_rsvd),
    .proto_i (proto),
    .vld_o   (mul_vld),
    .rsvd_o  (mul_rsvd),
    .pp_o    (mul_pp)
  );

  vsid_fold #(.ID_W(ID_W), .MULT_W(MULT_W), .N_SLICE(N_SLICE)) u_fold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (mul_vld),
    .rsvd_i (mul_rsvd),
    .pp_i   (mul_pp),
    .vld_o  (done_o),
    .rsvd_o (rsvd_o),
    .vsid_o (vsid_o)
  );
endmodule

// File: rtl/vsid_scramble_chk.sv
module vsid_scramble_chk #(
  parameter int unsigned ID_W  = 36,
  parameter int unsigned CTX_W = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              kernel_i,
  input logic [ID_W-1:0]   esid_i,
  input logic [CTX_W-1:0]  ctx_i,
  input logic              done_o,
  input logic [ID_W-1:0]   vsid_o,
  input logic              rsvd_o
);
  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##3 done_o); // R3
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 3)); // R3
  AST_NOT_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (vsid_o != {ID_W{1'b1}})); // R5
  AST_KERNEL_TOP_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && kernel_i && (&esid_i)) |-> ##3 rsvd_o); // R6
  AST_USER_NOT_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !kernel_i) |-> ##3 !rsvd_o); // R6
  AST_ZERO_MAPS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && kernel_i && (esid_i == '0)) |-> ##3 (vsid_o == '0)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(vsid_o) && $stable(rsvd_o))); // R9
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!done_o && !rsvd_o && vsid_o == '0)); // R8
endmodule

bind vsid_scramble vsid_scramble_chk #(.ID_W(ID_W), .CTX_W(CTX_W)) u_chk (.*);

// File: tb/vsid_scramble_tb.sv
`timescale 1ns/1ps
module vsid_scramble_tb;
  localparam longint unsigned MODV = 64'hF_FFFF_FFFF;
  localparam longint unsigned MULV = 64'd200730139;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        kernel_i = 1'b0;
  logic [35:0] esid_i = '0;
  logic [18:0] ctx_i = '0;
  logic        done_o, rsvd_o;
  logic [35:0] vsid_o;

  int checks = 0, errors = 0, e = 0;
  bit finished = 0;
  logic        hv[4];
  logic [35:0] hx[4];
  logic        hr[4];
  string       ht[4];
  logic [35:0] last_vsid = '0;
  logic        last_rsvd = 1'b0;

  always #2.5 clk_i = ~clk_i;

  vsid_scramble u_dut (.*);

  function automatic logic [35:0] proto_of(logic k, logic [35:0] s, logic [18:0] c);
    return k ? s : {1'b0, c, s[15:0]};
  endfunction

  function automatic logic [35:0] ref_vsid(logic [35:0] p);
    longint unsigned x = {28'd0, p};
    return 36'((x * MULV) % MODV);
  endfunction

  function automatic logic ref_rsvd(logic [35:0] p);
    return (p == 36'hF_FFFF_FFFF) || (p[35:34] == 2'b10);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic s, logic k, logic [35:0] es, logic [18:0] c, string tag);
    logic [35:0] p;
    int i;
    @(negedge clk_i);
    start_i = s; kernel_i = k; esid_i = es; ctx_i = c;
    p = proto_of(k, es, c);
    hv[e%4] = s; hx[e%4] = ref_vsid(p); hr[e%4] = ref_rsvd(p); ht[e%4] = tag;
    @(posedge clk_i); #1;
    i = (e + 2) % 4;
    chk(done_o == hv[i], "R3 done timing", 64'(done_o), 64'(hv[i]));
    if (hv[i]) begin
      chk(vsid_o == hx[i], ht[i], 64'(vsid_o), 64'(hx[i]));
      chk(rsvd_o == hr[i], "R6 reserved flag", 64'(rsvd_o), 64'(hr[i]));
      chk(vsid_o != 36'hF_FFFF_FFFF, "R5 never all ones", 64'(vsid_o), 64'h0);
    end else begin
      chk(vsid_o == last_vsid && rsvd_o == last_rsvd, "R9 hold while idle",
          64'(vsid_o), 64'(last_vsid));
    end
    last_vsid = vsid_o; last_rsvd = rsvd_o;
    e++;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h0005_eed1));
    for (int j = 0; j < 4; j++) begin hv[j] = 0; hx[j] = '0; hr[j] = 0; ht[j] = ""; end
    repeat (3) @(posedge clk_i);
    #1;
    chk(!done_o && !rsvd_o && vsid_o == '0, "R8 reset state", 64'(vsid_o), 64'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    // directed corners
    step(1, 1, 36'h0, 19'h0, "R7 zero proto");
    step(1, 1, 36'h1, 19'h0, "R1 kernel one");
    step(1, 1, 36'hF_FFFF_FFFF, 19'h0, "R1 kernel all ones");
    step(1, 1, 36'h8_1234_5678, 19'h0, "R1 kernel 10 prefix");
    step(1, 1, 36'hC_0000_0001, 19'h0, "R1 kernel 11 prefix");
    step(1, 0, 36'h0_0000_FFFF, 19'h7FFFF, "R2 user max");
    step(1, 0, 36'hF_FFFF_ABCD, 19'h12345, "R2 user upper esid ignored");
    step(1, 0, 36'h0_0000_ABCD, 19'h12345, "R2 user same low esid");
    step(0, 0, 36'h0, 19'h0, "idle");
    step(0, 1, 36'hF_FFFF_FFFF, 19'h0, "R9 idle inputs no effect");
    step(0, 0, 36'h0, 19'h0, "idle");
    step(0, 0, 36'h0, 19'h0, "idle");
    // back-to-back burst
    for (int j = 0; j < 16; j++)
      step(1, j[0], {$urandom, $urandom} & 64'hF_FFFF_FFFF, 19'($urandom), "R4 burst");
    // random mix
    for (int j = 0; j < 3000; j++) begin
      logic k = 1'($urandom);
      step(($urandom % 10) < 7, k, 36'({$urandom, $urandom}), 19'($urandom),
           k ? "R1 random kernel" : "R2 random user");
    end
    repeat (4) step(0, 0, 36'h0, 19'h0, "drain");
    summary();
  end
endmodule